// File: doc/BRIEF.md
# Entropy-Backed Random Word Register

This block keeps one 32-bit random word that it pulls from an external entropy source over a request/acknowledge handshake. Software sees two read-only locations through a simple read port made of a strobe and a byte address. One location returns the word itself and the other returns a small status word.

Reading a valid word has a side-effect. The word is handed out, marked invalid and cleared, and a refill request to the entropy source starts at once. While no valid word is held, the word location reads as zero and a request stays outstanding. The word becomes valid again only when the source acknowledges with good data. An acknowledge that signals a fetch error sets a sticky error flag and keeps the request raised, so the fetch is retried.

Top module: `rnd_word_reg`

## Requirements
- R1: After reset the word is invalid, the word location reads 0x0, the status location reads 0x0 and `ent_req` is high.
- R2: `ent_req` stays high from cycle to cycle until an acknowledge arrives while it is high.
- R3: An acknowledge with `ent_err` low while `ent_req` is high captures `ent_data`. From the next cycle the word is valid, the status valid bit (bit 0) is 1 and `ent_req` is low.
- R4: A read of the word location (byte address 0x0) while the word is valid returns the held word in the same cycle. From the next cycle the word is invalid and `ent_req` is high.
- R5: Whenever the word is invalid, a read of the word location returns 0x0.
- R6: A read of the word location while the word is invalid has no side-effect: `ent_req`, the valid bit and the error bit are unchanged.
- R7: An acknowledge that arrives while `ent_req` is low is ignored. The held word and the valid bit do not change.
- R8: An acknowledge with `ent_err` high while `ent_req` is high sets the status error bit (bit 1), leaves the word invalid and keeps `ent_req` high. The error bit clears on the next good delivery.
- R9: The status location (byte address 0x4) returns the valid flag in bit 0 and the error flag in bit 1, with all higher bits zero. Reading it has no side-effect.
- R10: A read at any other address returns 0x0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from the strobe and address |
| ent_req | output | 1 | Request to the entropy source |
| ent_ack | input | 1 | Acknowledge from the entropy source |
| ent_data | input | 32 | Random data, taken on an acknowledge |
| ent_err | input | 1 | Fetch error qualifier for the acknowledge |

## Verification
The checker verifies the handshake protocol on every cycle: a request is held until an acknowledge, a request drops after a good acknowledge and is kept after a failed one, the held-valid state and the outstanding request never coincide, and the word location reads zero whenever the word is invalid. It also checks the consume side-effect of a valid read and the absence of one for an invalid read. Only the bench scenarios can show the exact data values: that the word captured on an acknowledge is the word returned later, that a stray acknowledge leaves the held word unchanged, that the error flag clears after a retry, and that reset recovers from a valid state.

// File: rtl/rnd_word_pkg.sv
package rnd_word_pkg;

    // Read target selected by the address decoder
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_WORD = 2'd1,
        TGT_STAT = 2'd2
    } rd_tgt_e;

    // Status word bit positions (software decodes these)
    localparam int unsigned STAT_VALID_BIT = 0;
    localparam int unsigned STAT_ERR_BIT   = 1;

    // Handshake state of the fetch unit
    typedef struct packed {
        logic req;
    } fetch_state_t;

endpackage

// File: rtl/rnd_fetch.sv
// Request/acknowledge sequencer towards the entropy source.
module rnd_fetch
    import rnd_word_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic refill,
    input  logic ent_ack,
    input  logic ent_err,
    output logic ent_req,
    output logic deliver,
    output logic fail
);

    fetch_state_t st_d, st_q;
    logic         hs_done;

    always_comb begin
        st_d    = st_q;
        hs_done = st_q.req && ent_ack;
        deliver = hs_done && !ent_err;
        fail    = hs_done && ent_err;
        if (hs_done) begin
            // a failed fetch keeps asking, a good one completes
            st_d.req = ent_err;
        end else if (refill) begin
            st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_req = st_q.req;

endmodule

// File: rtl/rnd_store.sv
// Holds the random word plus its valid and error flags.
module rnd_store #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic              fail,
    input  logic              consume,
    input  logic [WORD_W-1:0] ent_data,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              err
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              err;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (deliver) begin
            st_d.word  = ent_data;
            st_d.valid = 1'b1;
            st_d.err   = 1'b0;
        end else if (fail) begin
            st_d.err = 1'b1;
        end
        if (consume) begin
            st_d.word  = '0;
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word  = st_q.word;
    assign valid = st_q.valid;
    assign err   = st_q.err;

endmodule

// File: rtl/rnd_rdmux.sv
// Address decode, read data selection and read side-effect detection.
module rnd_rdmux
    import rnd_word_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WORD_ADDR = 0,
    parameter int unsigned STAT_ADDR = 4
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] word,
    input  logic              valid,
    input  logic              err,
    output logic [WORD_W-1:0] rd_data,
    output logic              consume
);

    localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(WORD_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    rd_tgt_e           tgt;
    logic [WORD_W-1:0] stat;

    always_comb begin
        stat                 = '0;
        stat[STAT_VALID_BIT] = valid;
        stat[STAT_ERR_BIT]   = err;
        if (!rd_en) begin
            tgt = TGT_NONE;
        end else if (rd_addr == WORD_A) begin
            tgt = TGT_WORD;
        end else if (rd_addr == STAT_A) begin
            tgt = TGT_STAT;
        end else begin
            tgt = TGT_NONE;
        end
        unique case (tgt)
            TGT_WORD: rd_data = valid ? word : '0;
            TGT_STAT: rd_data = stat;
            default:  rd_data = '0;
        endcase
        consume = (tgt == TGT_WORD) && valid;
    end

endmodule

// File: rtl/rnd_word_reg.sv
// Top: random word register refilled from an entropy source.
module rnd_word_reg #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WORD_ADDR = 0,
    parameter int unsigned STAT_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              ent_req,
    input  logic              ent_ack,
    input  logic [WORD_W-1:0] ent_data,
    input  logic              ent_err
);

    logic              deliver;
    logic              fail;
    logic              consume;
    logic [WORD_W-1:0] word_q;
    logic              word_valid;
    logic              word_err;

    rnd_fetch u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .refill  (consume),
        .ent_ack (ent_ack),
        .ent_err (ent_err),
        .ent_req (ent_req),
        .deliver (deliver),
        .fail    (fail)
    );

    rnd_store #(.WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .deliver  (deliver),
        .fail     (fail),
        .consume  (consume),
        .ent_data (ent_data),
        .word     (word_q),
        .valid    (word_valid),
        .err      (word_err)
    );

    rnd_rdmux #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .WORD_ADDR (WORD_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_rdmux (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .word    (word_q),
        .valid   (word_valid),
        .err     (word_err),
        .rd_data (rd_data),
        .consume (consume)
    );

endmodule

// File: rtl/rnd_word_reg_chk.sv
module rnd_word_reg_chk #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WORD_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic              ent_req,
    input logic              ent_ack,
    input logic              ent_err,
    input logic              valid,
    input logic              err
);

    localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(WORD_ADDR);

    logic word_rd;
    assign word_rd = rd_en && (rd_addr == WORD_A);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req && !ent_ack |=> ent_req);

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req && ent_ack && !ent_err |=> !ent_req && valid);

    // R8
    err_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req && ent_ack && ent_err |=> ent_req && err && !valid);

    // R4
    valid_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && ent_req));

    // R4
    consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_rd && valid |=> !valid && ent_req);

    // R5
    invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_rd && !valid |-> rd_data == '0);

    // R6
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_rd && !valid && !ent_ack |=> !valid && ent_req && $stable(err));

endmodule

bind rnd_word_reg rnd_word_reg_chk #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .WORD_ADDR (WORD_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ent_req (ent_req),
    .ent_ack (ent_ack),
    .ent_err (ent_err),
    .valid   (word_valid),
    .err     (word_err)
);

// File: tb/rnd_word_reg_tb.sv
module rnd_word_reg_tb;

    localparam int NV = 18;

    localparam logic [2:0] OP_IDLE = 3'd0;
    localparam logic [2:0] OP_RDW  = 3'd1;
    localparam logic [2:0] OP_RDS  = 3'd2;
    localparam logic [2:0] OP_RDX  = 3'd3;
    localparam logic [2:0] OP_ACK  = 3'd4;
    localparam logic [2:0] OP_AERR = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] din;
        logic [31:0] exp_rd;
        logic        exp_req;
    } vec_t;

    // Expected values follow the requirements: word at 0x0, status at 0x4
    // (bit0 valid, bit1 error), other addresses read zero.
    localparam vec_t VECS [NV] = '{
        '{OP_RDW,  32'h0,         32'h0,         1'b1}, // R5 R6
        '{OP_RDS,  32'h0,         32'h0,         1'b1}, // R9
        '{OP_ACK,  32'hA5A5_1234, 32'h0,         1'b0}, // R3
        '{OP_RDS,  32'h0,         32'h1,         1'b0}, // R3 R9
        '{OP_ACK,  32'hFFFF_FFFF, 32'h0,         1'b0}, // R7
        '{OP_RDW,  32'h0,         32'hA5A5_1234, 1'b1}, // R4 R7
        '{OP_RDS,  32'h0,         32'h0,         1'b1}, // R4
        '{OP_RDW,  32'h0,         32'h0,         1'b1}, // R5
        '{OP_AERR, 32'hDEAD_BEEF, 32'h0,         1'b1}, // R8
        '{OP_RDS,  32'h0,         32'h2,         1'b1}, // R8
        '{OP_RDW,  32'h0,         32'h0,         1'b1}, // R8
        '{OP_ACK,  32'h0000_0001, 32'h0,         1'b0}, // R8
        '{OP_RDS,  32'h0,         32'h1,         1'b0}, // R8
        '{OP_RDX,  32'h0,         32'h0,         1'b0}, // R10
        '{OP_RDW,  32'h0,         32'h1,         1'b1}, // R4
        '{OP_IDLE, 32'h0,         32'h0,         1'b1}, // R2
        '{OP_ACK,  32'h8000_0000, 32'h0,         1'b0}, // R3
        '{OP_RDW,  32'h0,         32'h8000_0000, 1'b1}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = 8'h0;
    logic [31:0] rd_data;
    logic        ent_req;
    logic        ent_ack = 1'b0;
    logic [31:0] ent_data = 32'h0;
    logic        ent_err = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rnd_word_reg u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ent_req  (ent_req),
        .ent_ack  (ent_ack),
        .ent_data (ent_data),
        .ent_err  (ent_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rd_en    = 1'b0;
        rd_addr  = 8'h0;
        ent_ack  = 1'b0;
        ent_err  = 1'b0;
        ent_data = 32'h0;
    endtask

    task automatic apply(input vec_t v);
        idle_inputs();
        case (v.op)
            OP_RDW:  begin rd_en = 1'b1; rd_addr = 8'h00; end
            OP_RDS:  begin rd_en = 1'b1; rd_addr = 8'h04; end
            OP_RDX:  begin rd_en = 1'b1; rd_addr = 8'h08; end
            OP_ACK:  begin ent_ack = 1'b1; ent_data = v.din; end
            OP_AERR: begin ent_ack = 1'b1; ent_err = 1'b1; ent_data = v.din; end
            default: ;
        endcase
    endtask

    // read at a negedge, sample half a cycle before the next edge
    task automatic read_now(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        rd_en   = 1'b1;
        rd_addr = a;
        #1 d = rd_data;
        @(posedge clk);
        #1 idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        do_reset();
        #1;
        // R1 reset state
        check("R1 req", {31'b0, ent_req}, 32'h1);
        read_now(8'h04, d);
        check("R1 status", d, 32'h0);
        read_now(8'h00, d);
        check("R1 word", d, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #1;
            if (VECS[i].op inside {OP_RDW, OP_RDS, OP_RDX})
                check($sformatf("vec%0d rd R4/R5/R9/R10", i), rd_data, VECS[i].exp_rd);
            @(posedge clk);
            #1;
            idle_inputs();
            check($sformatf("vec%0d req R2/R3/R6/R7/R8", i), {31'b0, ent_req},
                  {31'b0, VECS[i].exp_req});
        end

        // R2: request holds over a long wait with no acknowledge
        begin
            int drops = 0;
            for (int k = 0; k < 25; k++) begin
                @(negedge clk);
                if (!ent_req) drops++;
            end
            check("R2 hold", drops, 0);
        end

        // R1: reset from a valid state returns to the reset state
        @(negedge clk);
        ent_ack  = 1'b1;
        ent_data = 32'h1357_9BDF;
        @(posedge clk);
        #1 idle_inputs();
        read_now(8'h04, d);
        check("R3 valid before reset", d, 32'h1);
        do_reset();
        #1;
        check("R1 req after reset", {31'b0, ent_req}, 32'h1);
        read_now(8'h00, d);
        check("R1 word after reset", d, 32'h0);

        // R9: status read leaves the held word in place
        @(negedge clk);
        ent_ack  = 1'b1;
        ent_data = 32'h2468_ACE0;
        @(posedge clk);
        #1 idle_inputs();
        read_now(8'h04, d);
        read_now(8'h04, d);
        check("R9 status stable", d, 32'h1);
        read_now(8'h00, d);
        check("R9 word kept", d, 32'h2468_ACE0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule